// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Master

This block is the lowest layer of a single-wire bus master. From a system clock and a parameter that gives the number of clock cycles in one microsecond, it produces the bus time slots that the single-wire protocol needs. It drives the shared open-drain line through an active-high pull-low enable and reads the line back through a synchronizer. Software or a higher-level sequencer sends one command at a time on a valid/ready handshake. Each command is a bus reset with presence detection, a plain bit write, or a touch-bit. A touch-bit is a read slot when the bit is 1 and a write-0 slot when the bit is 0.

Every phase duration is multiplied by a runtime coefficient, so a slow bus or long cabling can be handled without changing the design. The coefficient is sampled when a command is accepted and holds for that whole command. When the command ends, the block raises a one-cycle completion pulse, and the result bit is valid in the same cycle. Byte assembly, device addressing, CRC and strong pull-up control belong to the layers above.

Top module: `owb_master`

## Requirements
- R1: During and after reset the block is idle: `reqReady` is 1, `busPullLow` is 0 and `done` is 0.
- R2: Command code 1 with `reqBit`=1 produces a write-1 slot. The line is pulled low for 6 µs and then released for 64 µs, so the command takes 70 µs and reports result 0.
- R3: Command code 1 with `reqBit`=0 produces a write-0 slot. The line is pulled low for 60 µs and then released for 10 µs, so the command takes 70 µs and reports result 0.
- R4: Command code 2 with `reqBit`=1 produces a read slot. The line is pulled low for 6 µs and released. The line is sampled 9 µs after the release and the block then waits a further 55 µs. The result is the sampled level: 0 when a device holds the line low at the sample point, otherwise 1.
- R5: Command code 2 with `reqBit`=0 produces a write-0 slot with the timing of R3. The result is 0 whatever the line does.
- R6: Command code 0 pulls the line low for 500 µs, releases it, and samples it 70 µs after the release. The result is 0 when a device answers low (present) and 1 when the line is high (absent).
- R7: After the presence sample, a reset command stays busy for a further 430 µs of recovery. The whole command takes 1000 µs before `done`.
- R8: Every phase duration is multiplied by `delayCoef`, which is taken at the accepting edge. A coefficient of 0 acts as 1. Changing `delayCoef` during a command has no effect on that command.
- R9: A command is accepted only while `reqReady` is 1. Requests raised while the block is busy are ignored and start no later slot.
- R10: Command code 3 is a no-operation. It is never accepted: the line stays released, `reqReady` stays 1 and no `done` follows.
- R11: `done` is high for exactly one cycle, with `result` valid and `reqReady` already 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Command request |
| reqCmd | input | 2 | Command code: 0 reset, 1 write bit, 2 touch bit, 3 no-op |
| reqBit | input | 1 | Bit for write and touch commands |
| reqReady | output | 1 | Idle and able to accept a command |
| delayCoef | input | COEF_W | Timing multiplier, 0 treated as 1 |
| busIn | input | 1 | Raw level of the bus line |
| busPullLow | output | 1 | Open-drain enable; 1 pulls the line low |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Sampled bit or presence result, valid with done |

## Verification
The bound checker watches several rules on every cycle. `done` is a one-cycle pulse that follows a busy cycle and coincides with ready. The line is never pulled low while the block reports ready. Every accepted command starts with the line pulled low, and a no-op code leaves the block idle. Only the bench scenarios can show the things that need an absolute time reference or a model of a device on the line. These are the exact low and total widths of each slot in clock cycles, how those widths scale with the coefficient, where the sample point falls relative to a device's answer window, and the value of each result.

// File: rtl/owb_pkg.sv
package owb_pkg;

  // Width of a phase duration expressed in microseconds (max 1023 us).
  localparam int US_W = 10;

  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TOUCH = 2'd2,
    CMD_NONE  = 2'd3
  } owbCmd_e;

  typedef enum logic [1:0] {
    SLOT_W1    = 2'd0,
    SLOT_W0    = 2'd1,
    SLOT_READ  = 2'd2,
    SLOT_RESET = 2'd3
  } owbSlot_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_MID  = 2'd2,
    S_TAIL = 2'd3
  } owbState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic            loadPhase;
    logic [US_W-1:0] phaseUs;
    logic            latchCoef;
    logic            clearResult;
    logic            capture;
  } owbStrobe_t;

endpackage

// File: rtl/owb_datapath.sv
module owb_datapath
  import owb_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int COEF_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COEF_W-1:0] delayCoef,
  input  logic              busIn,
  input  owbStrobe_t        strb,
  output logic              phaseEnd,
  output logic              result
);

  localparam int CNT_W = US_W + COEF_W;
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLKS_PER_US - 1);

  // Line synchronizer; idle line reads high.
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= busIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end
  logic lineLevel;
  assign lineLevel = syncQ[SYNC_STAGES-1];

  // Coefficient: zero behaves as one; captured at command acceptance.
  logic [COEF_W-1:0] coefEff;
  logic [COEF_W-1:0] coefReg;
  logic [COEF_W-1:0] coefUse;
  assign coefEff = (delayCoef == '0) ? COEF_W'(1) : delayCoef;
  assign coefUse = strb.latchCoef ? coefEff : coefReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               coefReg <= COEF_W'(1);
    else if (strb.latchCoef) coefReg <= coefEff;
  end

  // Microsecond prescaler and phase down-counter.
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] usCnt;
  logic [CNT_W-1:0] loadVal;
  logic             usTick;

  assign loadVal  = CNT_W'(strb.phaseUs) * CNT_W'(coefUse);
  assign usTick   = (preCnt == '0);
  assign phaseEnd = (usCnt == CNT_W'(1)) && usTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usCnt  <= '0;
      preCnt <= '0;
    end else if (strb.loadPhase) begin
      usCnt  <= loadVal;
      preCnt <= PRE_MAX;
    end else if (usCnt != '0) begin
      if (usTick) begin
        usCnt  <= usCnt - CNT_W'(1);
        preCnt <= PRE_MAX;
      end else begin
        preCnt <= preCnt - PRE_W'(1);
      end
    end
  end

  // Result register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 result <= 1'b0;
    else if (strb.clearResult) result <= 1'b0;
    else if (strb.capture)     result <= lineLevel;
  end

endmodule

// File: rtl/owb_ctrl.sv
module owb_ctrl
  import owb_pkg::*;
#(
  parameter int W1_LOW_US   = 6,
  parameter int W1_REL_US   = 64,
  parameter int W0_LOW_US   = 60,
  parameter int W0_REL_US   = 10,
  parameter int RD_LOW_US   = 6,
  parameter int RD_SMP_US   = 9,
  parameter int RD_TAIL_US  = 55,
  parameter int RST_LOW_US  = 500,
  parameter int RST_SMP_US  = 70,
  parameter int RST_TAIL_US = 430
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       reqBit,
  input  logic       phaseEnd,
  output logic       reqReady,
  output logic       busPullLow,
  output logic       done,
  output owbStrobe_t strb
);

  owbState_e state, stateNext;
  owbSlot_e  slot, slotNext;
  logic      doneNext;

  function automatic logic [US_W-1:0] lowUsOf(owbSlot_e s);
    case (s)
      SLOT_W1:   return US_W'(W1_LOW_US);
      SLOT_W0:   return US_W'(W0_LOW_US);
      SLOT_READ: return US_W'(RD_LOW_US);
      default:   return US_W'(RST_LOW_US);
    endcase
  endfunction

  function automatic logic [US_W-1:0] midUsOf(owbSlot_e s);
    case (s)
      SLOT_W1:   return US_W'(W1_REL_US);
      SLOT_W0:   return US_W'(W0_REL_US);
      SLOT_READ: return US_W'(RD_SMP_US);
      default:   return US_W'(RST_SMP_US);
    endcase
  endfunction

  function automatic logic [US_W-1:0] tailUsOf(owbSlot_e s);
    return (s == SLOT_READ) ? US_W'(RD_TAIL_US) : US_W'(RST_TAIL_US);
  endfunction

  function automatic owbSlot_e pickSlot(logic [1:0] cmd, logic b);
    case (owbCmd_e'(cmd))
      CMD_RESET: return SLOT_RESET;
      CMD_TOUCH: return b ? SLOT_READ : SLOT_W0;
      default:   return b ? SLOT_W1 : SLOT_W0;
    endcase
  endfunction

  always_comb begin
    stateNext = state;
    slotNext  = slot;
    doneNext  = 1'b0;
    strb      = '0;
    case (state)
      S_IDLE: begin
        if (reqValid && (owbCmd_e'(reqCmd) != CMD_NONE)) begin
          slotNext         = pickSlot(reqCmd, reqBit);
          strb.loadPhase   = 1'b1;
          strb.phaseUs     = lowUsOf(slotNext);
          strb.latchCoef   = 1'b1;
          strb.clearResult = 1'b1;
          stateNext        = S_LOW;
        end
      end
      S_LOW: begin
        if (phaseEnd) begin
          strb.loadPhase = 1'b1;
          strb.phaseUs   = midUsOf(slot);
          stateNext      = S_MID;
        end
      end
      S_MID: begin
        if (phaseEnd) begin
          if (slot == SLOT_READ || slot == SLOT_RESET) begin
            strb.capture   = 1'b1;
            strb.loadPhase = 1'b1;
            strb.phaseUs   = tailUsOf(slot);
            stateNext      = S_TAIL;
          end else begin
            doneNext  = 1'b1;
            stateNext = S_IDLE;
          end
        end
      end
      default: begin
        if (phaseEnd) begin
          doneNext  = 1'b1;
          stateNext = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      slot  <= SLOT_W1;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      slot  <= slotNext;
      done  <= doneNext;
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign busPullLow = (state == S_LOW);

endmodule

// File: rtl/owb_master.sv
module owb_master
  import owb_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int COEF_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic              reqBit,
  output logic              reqReady,
  input  logic [COEF_W-1:0] delayCoef,
  input  logic              busIn,
  output logic              busPullLow,
  output logic              done,
  output logic              result
);

  owbStrobe_t strb;
  logic       phaseEnd;

  owb_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqCmd     (reqCmd),
    .reqBit     (reqBit),
    .phaseEnd   (phaseEnd),
    .reqReady   (reqReady),
    .busPullLow (busPullLow),
    .done       (done),
    .strb       (strb)
  );

  owb_datapath #(
    .CLKS_PER_US (CLKS_PER_US),
    .COEF_W      (COEF_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .delayCoef (delayCoef),
    .busIn     (busIn),
    .strb      (strb),
    .phaseEnd  (phaseEnd),
    .result    (result)
  );

endmodule

// File: rtl/owb_master_chk.sv
module owb_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqCmd,
  input logic       reqReady,
  input logic       busPullLow,
  input logic       done
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !$past(reqReady));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busPullLow);

  // R9
  accept_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqCmd != 2'd3) |=> (busPullLow && !reqReady));

  // R10
  nop_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqCmd == 2'd3) |=> (reqReady && !busPullLow && !done));

endmodule

bind owb_master owb_master_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqCmd     (reqCmd),
  .reqReady   (reqReady),
  .busPullLow (busPullLow),
  .done       (done)
);

// File: tb/owb_master_tb_top.sv
module owb_master_tb_top;

  localparam int CLK_US = 2;
  localparam int COEF_W = 4;
  localparam int NVEC   = 13;

  typedef struct packed {
    logic [1:0]  cmd;
    logic        bitv;
    logic [3:0]  coef;
    logic        dev;
    logic [15:0] ws;
    logic [15:0] we;
    logic [15:0] lowUs;
    logic [15:0] totUs;
    logic        res;
  } vec_t;

  // window ws..we is in clock cycles after the master releases the line
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b1, 4'd1, 1'b0, 16'd0,  16'd0,   16'd6,   16'd70,   1'b0}, // R2
    '{2'd1, 1'b0, 4'd1, 1'b0, 16'd0,  16'd0,   16'd60,  16'd70,   1'b0}, // R3
    '{2'd2, 1'b1, 4'd1, 1'b1, 16'd0,  16'd40,  16'd6,   16'd70,   1'b0}, // R4
    '{2'd2, 1'b1, 4'd1, 1'b0, 16'd0,  16'd0,   16'd6,   16'd70,   1'b1}, // R4
    '{2'd2, 1'b1, 4'd1, 1'b1, 16'd0,  16'd8,   16'd6,   16'd70,   1'b1}, // R4
    '{2'd2, 1'b0, 4'd1, 1'b1, 16'd0,  16'd40,  16'd60,  16'd70,   1'b0}, // R5
    '{2'd2, 1'b1, 4'd2, 1'b1, 16'd0,  16'd60,  16'd6,   16'd70,   1'b0}, // R4 R8
    '{2'd2, 1'b1, 4'd2, 1'b1, 16'd0,  16'd20,  16'd6,   16'd70,   1'b1}, // R4 R8
    '{2'd0, 1'b0, 4'd1, 1'b1, 16'd30, 16'd300, 16'd500, 16'd1000, 1'b0}, // R6 R7
    '{2'd0, 1'b1, 4'd1, 1'b0, 16'd0,  16'd0,   16'd500, 16'd1000, 1'b1}, // R6 R7
    '{2'd0, 1'b0, 4'd3, 1'b1, 16'd60, 16'd900, 16'd500, 16'd1000, 1'b0}, // R6 R8
    '{2'd1, 1'b1, 4'd3, 1'b0, 16'd0,  16'd0,   16'd6,   16'd70,   1'b0}, // R2 R8
    '{2'd1, 1'b0, 4'd0, 1'b0, 16'd0,  16'd0,   16'd60,  16'd70,   1'b0}  // R8 zero
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqCmd;
  logic              reqBit;
  logic              reqReady;
  logic [COEF_W-1:0] delayCoef;
  logic              busIn;
  logic              busPullLow;
  logic              done;
  logic              result;

  int checks = 0;
  int errors = 0;

  // device model on the line
  logic devOn = 1'b0;
  int   winStart = 0;
  int   winEnd = 0;
  int   relCnt = 1000000;
  logic devLow;

  always @(negedge clk) begin
    if (busPullLow) relCnt <= 0;
    else            relCnt <= relCnt + 1;
  end
  assign devLow = devOn && !busPullLow && (relCnt >= winStart) && (relCnt < winEnd);
  assign busIn  = !(busPullLow || devLow);

  owb_master #(.CLKS_PER_US(CLK_US), .COEF_W(COEF_W), .SYNC_STAGES(2)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqCmd     (reqCmd),
    .reqBit     (reqBit),
    .reqReady   (reqReady),
    .delayCoef  (delayCoef),
    .busIn      (busIn),
    .busPullLow (busPullLow),
    .done       (done),
    .result     (result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.cmd == 2'd0) return "R6";
    if (v.cmd == 2'd1) return v.bitv ? "R2" : "R3";
    return v.bitv ? "R4" : "R5";
  endfunction

  // poke 1: raise a reset request while busy; poke 2: change coefficient mid-slot
  task automatic runCmd(input logic [1:0] c, input logic b, input logic [3:0] k, input int poke,
                        output int lowC, output int totC, output logic res,
                        output logic doneAfter, output logic rdyAtDone);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = c; reqBit = b; delayCoef = k;
    @(negedge clk);
    reqValid = 1'b0;
    lowC = 0; totC = 0;
    while (!done && totC < 20000) begin
      if (busPullLow) lowC++;
      totC++;
      if (poke == 1 && totC == 5)  begin reqValid = 1'b1; reqCmd = 2'd0; end
      if (poke == 1 && totC == 15) reqValid = 1'b0;
      if (poke == 2 && totC == 10) delayCoef = 4'd3;
      @(negedge clk);
    end
    res = result;
    rdyAtDone = reqReady;
    @(negedge clk);
    doneAfter = done;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lowC, totC, k, quietBad;
    logic res, doneAfter, rdy;
    rstN = 1'b0; reqValid = 1'b0; reqCmd = 2'd0; reqBit = 1'b0; delayCoef = 4'd1;
    repeat (4) @(negedge clk);
    // R1 during reset
    check(reqReady && !busPullLow && !done, "R1 in reset", {busPullLow, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady && !busPullLow && !done, "R1 after reset", reqReady, 1);

    for (int i = 0; i < NVEC; i++) begin
      devOn = VECS[i].dev; winStart = VECS[i].ws; winEnd = VECS[i].we;
      k = (VECS[i].coef == 0) ? 1 : int'(VECS[i].coef);
      runCmd(VECS[i].cmd, VECS[i].bitv, VECS[i].coef, 0, lowC, totC, res, doneAfter, rdy);
      check(lowC == VECS[i].lowUs * k * CLK_US, {tagOf(VECS[i]), " low width"},
            lowC, VECS[i].lowUs * k * CLK_US);
      check(totC == VECS[i].totUs * k * CLK_US,
            (VECS[i].cmd == 2'd0) ? "R7 total busy" : {tagOf(VECS[i]), " total busy"},
            totC, VECS[i].totUs * k * CLK_US);
      check(res == VECS[i].res, {tagOf(VECS[i]), " result"}, res, VECS[i].res);
      if (VECS[i].coef != 4'd1)
        check(totC == VECS[i].totUs * k * CLK_US, "R8 scaled duration", totC, VECS[i].totUs * k * CLK_US);
      check(rdy && !doneAfter, "R11 done pulse and ready", {rdy, doneAfter}, 2);
      devOn = 1'b0;
    end

    // R9: request while busy is ignored
    runCmd(2'd1, 1'b0, 4'd1, 1, lowC, totC, res, doneAfter, rdy);
    check(totC == 70 * CLK_US, "R9 busy slot length", totC, 70 * CLK_US);
    quietBad = 0;
    repeat (40) begin
      @(negedge clk);
      if (busPullLow || !reqReady || done) quietBad++;
    end
    check(quietBad == 0, "R9 no late slot", quietBad, 0);

    // R8: coefficient change during a slot has no effect
    runCmd(2'd1, 1'b0, 4'd1, 2, lowC, totC, res, doneAfter, rdy);
    check(totC == 70 * CLK_US && lowC == 60 * CLK_US, "R8 mid-slot coef", totC, 70 * CLK_US);
    delayCoef = 4'd1;

    // R10: no-op code
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 2'd3; reqBit = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    quietBad = 0;
    repeat (40) begin
      if (busPullLow || !reqReady || done) quietBad++;
      @(negedge clk);
    end
    check(quietBad == 0, "R10 no-op ignored", quietBad, 0);

    // R5 again with device holding line low for whole window: touch-0 still 0
    devOn = 1'b1; winStart = 0; winEnd = 100000;
    runCmd(2'd2, 1'b0, 4'd1, 0, lowC, totC, res, doneAfter, rdy);
    check(res == 1'b0, "R5 touch-0 result", res, 0);
    devOn = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule